// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous EDO DRAM alive and brings it up after power-on. Once reset is released it holds every strobe inactive for a fixed settling pause. It then owns the memory bus by itself and runs a back-to-back burst of warm-up refresh cycles. Only after the last of these has finished does it raise `init_done`, which the access sequencer uses to gate its own ready.

From then on an interval timer marks each moment a row refresh falls due. Due refreshes are counted in a small pending counter. While that counter is nonzero the block requests the bus. It starts a refresh only when the access sequencer grants, meaning the sequencer is idle with its page closed. The block gives the bus back by dropping `ref_own` at the end of the precharge.

A build-time choice selects the refresh style:
- **Counter-addressed refresh:** both CAS strobes lead the RAS fall, so the device supplies the row from its own counter.
- **Row-addressed refresh:** only RAS pulses, and the block drives the row from an internal counter.

A second build-time choice picks the short or long retention interval.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `lcas_n`, `ucas_n` and `we_n` are 1, and `init_done`, `ref_req`, `ref_own`, `pend_err` and `addr_oe` are 0.
- R2: For the first PAUSE_CYC clock cycles after reset release, all strobes stay inactive. The first strobe activity (CAS low in counter mode, RAS low in row mode) appears in cycle PAUSE_CYC+1, counting the first rising edge after release as cycle 1.
- R3: After the pause, exactly INIT_REFS refresh cycles run back to back, with one idle cycle between them, without waiting for `seq_gnt`. `init_done` rises in the cycle after the last precharge cycle ends and stays high.
- R4: In counter mode, `lcas_n` and `ucas_n` fall together T_LEAD cycles before `ras_n` falls. They stay low for the whole RAS-low time and return high together with `ras_n`.
- R5: Every RAS-low pulse lasts exactly T_ACT cycles. Between two pulses, RAS stays high for at least T_PRE cycles.
- R6: `we_n` is 1 in every cycle.
- R7: In row mode, both CAS strobes stay high, and `addr_oe` is 1 while RAS is low. `row_addr` at each RAS fall equals the number of earlier refresh cycles modulo 2^ROW_W, starting at 0.
- R8: A refresh falls due every INTERVAL cycles after `init_done` rises. INTERVAL is INT_LP when LOW_POWER=1 and INT_STD otherwise. The first due refresh raises `ref_req` exactly INTERVAL cycles after the first cycle in which `init_done` is high. With `seq_gnt` held high, RAS falls T_LEAD+1 cycles after each due point in counter mode, and 1 cycle after it in row mode.
- R9: After init, a refresh starts only in a cycle where `seq_gnt` is high. `ref_own` is high for exactly the cycles of a refresh (lead, RAS-low and precharge), and every strobe activity falls inside `ref_own`.
- R10: Up to PEND_MAX due refreshes are held while the grant is withheld. A refresh that falls due when PEND_MAX are already pending is dropped and sets `pend_err`, which stays set until reset. A later grant runs exactly the held count.
- R11: `ref_req` is high exactly when `init_done` is high and at least one refresh is pending and not yet started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| seq_gnt | input | 1 | Access sequencer is idle with its page closed and yields the bus |
| ref_req | output | 1 | A refresh is pending and the bus is wanted |
| ref_own | output | 1 | This block drives the DRAM strobes |
| ras_n | output | 1 | Row strobe |
| lcas_n | output | 1 | Lower-byte column strobe |
| ucas_n | output | 1 | Upper-byte column strobe |
| we_n | output | 1 | Write enable, held inactive |
| addr_oe | output | 1 | Drive `row_addr` onto the address bus (row mode only) |
| row_addr | output | ROW_W | Row for row-addressed refresh |
| init_done | output | 1 | Pause and warm-up burst both complete |
| pend_err | output | 1 | Sticky: a due refresh was lost at a full pending counter |

## Verification
The bench targets the exact cycle of the first strobe, the RAS fall, `init_done` and the first request. A pause or burst counter that is off by one, or an interval that starts counting one cycle late, moves one of these by a cycle.

The grant is withheld across five due points. This checks that the pending count stops at four, that the fifth point sets the sticky error, and that a late grant runs exactly four cycles. A counter that wraps would run too few cycles; one that does not saturate would run five.

A row-mode instance with a three-bit row counter wraps during the warm-up burst itself. A counter that skips a row, or that advances at the RAS fall instead of after precharge, therefore shows the wrong address at the ninth pulse.

// File: rtl/drs_pkg.sv
package drs_pkg;

  // Phases of one refresh cycle on the strobes.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,  // CAS low, RAS high (counter mode only)
    PH_ACT  = 2'd2,  // RAS low
    PH_PRE  = 2'd3   // all strobes high, precharge
  } ref_phase_t;

  typedef enum logic [1:0] {
    IS_PAUSE = 2'd0,
    IS_BURST = 2'd1,
    IS_RUN   = 2'd2
  } init_state_t;

  localparam int unsigned REF_CBR = 0;  // device supplies the row
  localparam int unsigned REF_ROW = 1;  // controller supplies the row

  // Bits needed to hold the values 0 .. n-1.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer
  import drs_pkg::*;
#(
  parameter int unsigned INTERVAL = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int unsigned CW = cnt_w(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick) else $error("timer ticked while disabled"); // R8

endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr
  import drs_pkg::*;
#(
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic take,
  output logic nonzero,
  output logic err
);

  localparam int unsigned CW = cnt_w(PEND_MAX + 1);
  localparam logic [CW-1:0] FULL = CW'(PEND_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_set;

  always_comb begin
    cnt_d   = cnt_q;
    err_set = 1'b0;
    unique case ({due, take})
      2'b10: begin
        if (cnt_q == FULL) err_set = 1'b1;
        else               cnt_d   = cnt_q + 1'b1;
      end
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign nonzero = (cnt_q != '0);
  assign err     = err_q;

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL) else $error("pending count above limit"); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err) else $error("error flag cleared"); // R10
  AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> nonzero) else $error("refresh taken with none pending"); // R10

endmodule

// File: rtl/drs_cycle_gen.sv
module drs_cycle_gen
  import drs_pkg::*;
#(
  parameter int unsigned MODE   = REF_CBR,
  parameter int unsigned T_LEAD = 2,
  parameter int unsigned T_ACT  = 13,
  parameter int unsigned T_PRE  = 8,
  parameter int unsigned ROW_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             ras_n,
  output logic             lcas_n,
  output logic             ucas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr
);

  localparam int unsigned T_MAX0 = (T_LEAD > T_ACT) ? T_LEAD : T_ACT;
  localparam int unsigned T_MAX  = (T_MAX0 > T_PRE) ? T_MAX0 : T_PRE;
  localparam int unsigned CW     = cnt_w(T_MAX);
  localparam logic [CW-1:0] LEAD_LD = CW'(T_LEAD - 1);
  localparam logic [CW-1:0] ACT_LD  = CW'(T_ACT - 1);
  localparam logic [CW-1:0] PRE_LD  = CW'(T_PRE - 1);
  localparam bit USE_CAS = (MODE == REF_CBR);

  ref_phase_t    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ras_q, ras_d;
  logic          cas_q, cas_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (USE_CAS) begin
            phase_d = PH_LEAD;
            cnt_d   = LEAD_LD;
          end else begin
            phase_d = PH_ACT;
            cnt_d   = ACT_LD;
          end
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACT;
          cnt_d   = ACT_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACT: begin
        if (cnt_q == '0) begin
          phase_d = PH_PRE;
          cnt_d   = PRE_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PRE: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Strobes are registered from the next phase so they change cleanly
  // and line up with phase_q.
  always_comb begin
    ras_d = (phase_d != PH_ACT);
    cas_d = !(USE_CAS && ((phase_d == PH_LEAD) || (phase_d == PH_ACT)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign ras_n  = ras_q;
  assign lcas_n = cas_q;  // both bytes move together, never staggered
  assign ucas_n = cas_q;

  generate
    if (MODE == REF_ROW) begin : g_row
      logic [ROW_W-1:0] row_q;
      logic             oe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q <= '0;
          oe_q  <= 1'b0;
        end else begin
          if (done) row_q <= row_q + 1'b1;
          oe_q <= (phase_d != PH_IDLE);
        end
      end
      assign row_addr = row_q;
      assign addr_oe  = oe_q;

      AST_ROW_CAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lcas_n && ucas_n && addr_oe)) else $error("row mode strobe fault"); // R7
      AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (row_addr == ROW_W'($past(row_addr) + 1'b1))) else $error("row did not step"); // R7
    end else begin : g_cbr
      assign row_addr = '0;
      assign addr_oe  = 1'b0;

      AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!lcas_n && !ucas_n)) else $error("CAS did not lead RAS"); // R4
      AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (!lcas_n && !ucas_n)) else $error("CAS released during RAS low"); // R4
    end
  endgenerate

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("start while busy"); // R9

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int unsigned MODE      = REF_CBR,
  parameter int unsigned LOW_POWER = 0,
  parameter int unsigned PAUSE_CYC = 25000,  // 100 us at 4 ns
  parameter int unsigned INT_STD   = 3900,   // just under 16 ms / 1024 rows
  parameter int unsigned INT_LP    = 31200,  // just under 128 ms / 1024 rows
  parameter int unsigned T_LEAD    = 2,      // CAS before RAS, >= 5 ns
  parameter int unsigned T_ACT     = 13,     // RAS low, >= 50 ns
  parameter int unsigned T_PRE     = 8,      // RAS precharge, >= 30 ns
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned PEND_MAX  = 4,
  parameter int unsigned ROW_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_gnt,
  output logic             ref_req,
  output logic             ref_own,
  output logic             ras_n,
  output logic             lcas_n,
  output logic             ucas_n,
  output logic             we_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             init_done,
  output logic             pend_err
);

  localparam int unsigned INTERVAL = (LOW_POWER != 0) ? INT_LP : INT_STD;
  localparam int unsigned PW       = cnt_w(PAUSE_CYC);
  localparam int unsigned BW       = cnt_w(INIT_REFS);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [BW-1:0] BURST_LAST = BW'(INIT_REFS - 1);

  init_state_t   state_q, state_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [BW-1:0] burst_q, burst_d;

  logic start, take, busy, done, tick, pend_nz, run;

  assign run = (state_q == IS_RUN);

  // Power-up sequence: settle, warm-up burst, then normal refresh.
  always_comb begin
    state_d = state_q;
    pause_d = pause_q;
    burst_d = burst_q;
    unique case (state_q)
      IS_PAUSE: begin
        if (pause_q == PAUSE_LAST) state_d = IS_BURST;
        else                       pause_d = pause_q + 1'b1;
      end
      IS_BURST: begin
        if (done) begin
          if (burst_q == BURST_LAST) state_d = IS_RUN;
          else                       burst_d = burst_q + 1'b1;
        end
      end
      IS_RUN:  state_d = IS_RUN;
      default: state_d = IS_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IS_PAUSE;
      pause_q <= '0;
      burst_q <= '0;
    end else begin
      state_q <= state_d;
      pause_q <= pause_d;
      burst_q <= burst_d;
    end
  end

  // Warm-up cycles own the bus outright; later ones wait for the grant.
  always_comb begin
    take  = run && !busy && pend_nz && seq_gnt;
    start = take || ((state_q == IS_BURST) && !busy);
  end

  drs_interval_timer #(
    .INTERVAL (INTERVAL)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run),
    .tick  (tick)
  );

  drs_pend_ctr #(
    .PEND_MAX (PEND_MAX)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .due     (tick),
    .take    (take),
    .nonzero (pend_nz),
    .err     (pend_err)
  );

  drs_cycle_gen #(
    .MODE   (MODE),
    .T_LEAD (T_LEAD),
    .T_ACT  (T_ACT),
    .T_PRE  (T_PRE),
    .ROW_W  (ROW_W)
  ) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .addr_oe  (addr_oe),
    .row_addr (row_addr)
  );

  assign init_done = run;
  assign ref_req   = run && pend_nz;
  assign ref_own   = busy;
  assign we_n      = 1'b1;

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IS_PAUSE) |-> (ras_n && lcas_n && ucas_n)) else $error("strobe during pause"); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done) else $error("init_done fell"); // R3
  AST_OWN_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $rose(ref_own)) |-> $past(seq_gnt)) else $error("bus taken without grant"); // R9
  AST_REQ_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> init_done) else $error("request before init"); // R11

endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps

module drs_mon #(
  parameter int MODE = 0,
  parameter int TL   = 2,
  parameter int TA   = 13,
  parameter int TP   = 8,
  parameter int ROWN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  int          cyc,
  input  logic        ras_n,
  input  logic        lcas_n,
  input  logic        ucas_n,
  input  logic        we_n,
  input  logic        addr_oe,
  input  logic [15:0] row,
  input  logic        own,
  input  logic        req,
  input  logic        idone,
  output int          pulses,
  output int          first_ras,
  output int          first_cas,
  output int          init_rise,
  output int          pulses_at_init,
  output int          first_req,
  output int          last_fall,
  output int          prev_fall,
  output int          bad_lead,
  output int          bad_act,
  output int          bad_gap,
  output int          bad_we,
  output int          bad_row,
  output int          bad_own
);
  localparam int LEN = ((MODE == 0) ? TL : 0) + TA + TP;
  int csr_run, act_run, high_run, own_run;
  logic p_ras, p_own, p_done, p_req;

  always @(negedge clk) begin
    if (!rst_n) begin
      pulses = 0; first_ras = -1; first_cas = -1; init_rise = -1; pulses_at_init = -1;
      first_req = -1; last_fall = -1; prev_fall = -1;
      bad_lead = 0; bad_act = 0; bad_gap = 0; bad_we = 0; bad_row = 0; bad_own = 0;
      csr_run = 0; act_run = 0; high_run = 0; own_run = 0;
      p_ras = 1'b1; p_own = 1'b0; p_done = 1'b0; p_req = 1'b0;
    end else begin
      if (we_n !== 1'b1) bad_we++;
      if ((!ras_n || !lcas_n || !ucas_n) && !own) bad_own++;
      if (own) own_run++;
      else if (p_own) begin
        if (own_run != LEN) bad_own++;
        own_run = 0;
      end
      if (first_cas < 0 && !lcas_n) first_cas = cyc;
      if (ras_n && !lcas_n && !ucas_n) csr_run++;
      else if (ras_n) csr_run = 0;
      if (!ras_n && p_ras) begin
        if (MODE == 0) begin
          if (csr_run != TL) bad_lead++;
        end else begin
          if (!lcas_n || !ucas_n || !addr_oe || (int'(row) != (pulses % ROWN))) bad_row++;
        end
        if (pulses > 0 && high_run < TP) bad_gap++;
        pulses++;
        if (first_ras < 0) first_ras = cyc;
        prev_fall = last_fall;
        last_fall = cyc;
        act_run = 0;
        csr_run = 0;
      end
      if (!ras_n) begin
        act_run++;
        high_run = 0;
        if (MODE == 0 && (lcas_n || ucas_n)) bad_lead++;
        if (MODE != 0 && (!lcas_n || !ucas_n || !addr_oe)) bad_row++;
      end else begin
        if (!p_ras) begin
          if (act_run != TA) bad_act++;
          if (MODE == 0 && !(lcas_n && ucas_n)) bad_lead++;
        end
        high_run++;
      end
      if (idone && !p_done) begin
        init_rise = cyc;
        pulses_at_init = pulses;
      end
      if (req && !p_req && first_req < 0) first_req = cyc;
      p_ras = ras_n; p_own = own; p_done = idone; p_req = req;
    end
  end
endmodule

module sim_dram_refresh_sched;
  localparam int P    = 20;
  localparam int TL   = 2;
  localparam int TA   = 13;
  localparam int TP   = 8;
  localparam int NREF = 8;
  localparam int I0   = 120;
  localparam int ILP  = 250;
  localparam int PMAX = 4;
  localparam int L0   = TL + TA + TP;
  localparam int L1   = TA + TP;
  localparam int D0   = P + NREF * L0 + NREF;
  localparam int D1   = P + NREF * L1 + NREF;
  localparam int WD   = 4000;

  logic clk, rst_n, gnt0, gnt1;
  logic req0, own0, ras0, lc0, uc0, we0, oe0, done0, err0;
  logic req1, own1, ras1, lc1, uc1, we1, oe1, done1, err1;
  logic [9:0] row0;
  logic [2:0] row1;
  int cyc;
  int checks, errors;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dram_refresh_sched #(
    .MODE(0), .LOW_POWER(0), .PAUSE_CYC(P), .INT_STD(I0), .INT_LP(ILP),
    .T_LEAD(TL), .T_ACT(TA), .T_PRE(TP), .INIT_REFS(NREF), .PEND_MAX(PMAX), .ROW_W(10)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .seq_gnt(gnt0), .ref_req(req0), .ref_own(own0),
    .ras_n(ras0), .lcas_n(lc0), .ucas_n(uc0), .we_n(we0), .addr_oe(oe0),
    .row_addr(row0), .init_done(done0), .pend_err(err0)
  );

  dram_refresh_sched #(
    .MODE(1), .LOW_POWER(1), .PAUSE_CYC(P), .INT_STD(I0), .INT_LP(ILP),
    .T_LEAD(TL), .T_ACT(TA), .T_PRE(TP), .INIT_REFS(NREF), .PEND_MAX(PMAX), .ROW_W(3)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .seq_gnt(gnt1), .ref_req(req1), .ref_own(own1),
    .ras_n(ras1), .lcas_n(lc1), .ucas_n(uc1), .we_n(we1), .addr_oe(oe1),
    .row_addr(row1), .init_done(done1), .pend_err(err1)
  );

  int m0_pulses, m0_fras, m0_fcas, m0_irise, m0_pinit, m0_freq, m0_last, m0_prev;
  int m0_blead, m0_bact, m0_bgap, m0_bwe, m0_brow, m0_bown;
  int m1_pulses, m1_fras, m1_fcas, m1_irise, m1_pinit, m1_freq, m1_last, m1_prev;
  int m1_blead, m1_bact, m1_bgap, m1_bwe, m1_brow, m1_bown;

  drs_mon #(.MODE(0), .TL(TL), .TA(TA), .TP(TP), .ROWN(1024)) mon0 (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .ras_n(ras0), .lcas_n(lc0), .ucas_n(uc0),
    .we_n(we0), .addr_oe(oe0), .row({6'b0, row0}), .own(own0), .req(req0), .idone(done0),
    .pulses(m0_pulses), .first_ras(m0_fras), .first_cas(m0_fcas), .init_rise(m0_irise),
    .pulses_at_init(m0_pinit), .first_req(m0_freq), .last_fall(m0_last), .prev_fall(m0_prev),
    .bad_lead(m0_blead), .bad_act(m0_bact), .bad_gap(m0_bgap), .bad_we(m0_bwe),
    .bad_row(m0_brow), .bad_own(m0_bown)
  );

  drs_mon #(.MODE(1), .TL(TL), .TA(TA), .TP(TP), .ROWN(8)) mon1 (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .ras_n(ras1), .lcas_n(lc1), .ucas_n(uc1),
    .we_n(we1), .addr_oe(oe1), .row({13'b0, row1}), .own(own1), .req(req1), .idone(done1),
    .pulses(m1_pulses), .first_ras(m1_fras), .first_cas(m1_fcas), .init_rise(m1_irise),
    .pulses_at_init(m1_pinit), .first_req(m1_freq), .last_fall(m1_last), .prev_fall(m1_prev),
    .bad_lead(m1_blead), .bad_act(m1_bact), .bad_gap(m1_bgap), .bad_we(m1_bwe),
    .bad_row(m1_brow), .bad_own(m1_bown)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, D0 + 7 * I0 + TL + 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rs0;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    gnt0 = 1'b0;
    gnt1 = 1'b1;
    repeat (3) @(negedge clk);
    rs0 = {ras0, lc0, uc0, we0, done0, req0, err0, own0};
    chk(rs0 == 8'b1111_0000, "R1 reset outputs u0", int'(rs0), 8'hF0);
    chk({ras1, lc1, uc1, oe1, row1} == 7'b1110_000, "R1 reset outputs u1",
        int'({ras1, lc1, uc1, oe1, row1}), 7'h70);
    rst_n = 1'b1;

    wait_cyc(P);
    chk(ras0 && lc0 && uc0 && ras1, "R2 strobes idle at end of pause",
        int'({ras0, lc0, uc0, ras1}), 15);

    wait_cyc(D0 + I0 + 2);
    chk(m0_fcas == P + 1, "R2 first CAS fall counter mode", m0_fcas, P + 1);
    chk(m1_fras == P + 1, "R2 first RAS fall row mode", m1_fras, P + 1);
    chk(m0_fras == P + 1 + TL, "R4 first RAS fall after lead", m0_fras, P + 1 + TL);
    chk(m0_irise == D0, "R3 init_done cycle counter mode", m0_irise, D0);
    chk(m1_irise == D1, "R3 init_done cycle row mode", m1_irise, D1);
    chk(m0_pinit == NREF, "R3 warm-up count counter mode", m0_pinit, NREF);
    chk(m1_pinit == NREF, "R3 warm-up count row mode", m1_pinit, NREF);
    chk(m0_freq == D0 + I0, "R8 first request standard interval", m0_freq, D0 + I0);
    chk(m0_pulses == NREF, "R9 no refresh without grant", m0_pulses, NREF);

    wait_cyc(D0 + 2 * I0 + 1);
    chk(req0 == 1'b1, "R11 request held while pending", int'(req0), 1);

    wait_cyc(D0 + 4 * I0 + 2);
    chk(err0 == 1'b0, "R10 no error at full count", int'(err0), 0);

    wait_cyc(D0 + 5 * I0 + 1);
    chk(err0 == 1'b1, "R10 error on fifth due point", int'(err0), 1);

    wait_cyc(D0 + 5 * I0 + 5);
    gnt0 = 1'b1;

    wait_cyc(D0 + 6 * I0 - 2);
    chk(m0_pulses == NREF + PMAX, "R10 held refreshes drained", m0_pulses, NREF + PMAX);
    chk(req0 == 1'b0, "R11 request low when drained", int'(req0), 0);
    chk(err0 == 1'b1, "R10 error sticky", int'(err0), 1);

    wait_cyc(D0 + 7 * I0 + TL + 3);
    chk(m0_prev == D0 + 6 * I0 + 1 + TL, "R8 granted refresh timing",
        m0_prev, D0 + 6 * I0 + 1 + TL);
    chk(m0_last == D0 + 7 * I0 + 1 + TL, "R8 refresh spacing",
        m0_last, D0 + 7 * I0 + 1 + TL);
    chk(m1_freq == D1 + ILP, "R8 first request long interval", m1_freq, D1 + ILP);
    chk(m1_pulses == NREF + 3, "R8 long interval count", m1_pulses, NREF + 3);
    chk(m1_last == D1 + 3 * ILP + 1, "R8 row mode refresh timing", m1_last, D1 + 3 * ILP + 1);
    chk(m0_blead == 0, "R4 CAS lead and hold", m0_blead, 0);
    chk(m0_bact + m1_bact == 0, "R5 RAS low width", m0_bact + m1_bact, 0);
    chk(m0_bgap + m1_bgap == 0, "R5 precharge width", m0_bgap + m1_bgap, 0);
    chk(m0_bwe + m1_bwe == 0, "R6 write enable inactive", m0_bwe + m1_bwe, 0);
    chk(m1_brow == 0, "R7 row address and CAS in row mode", m1_brow, 0);
    chk(m0_bown + m1_bown == 0, "R9 bus ownership window", m0_bown + m1_bown, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule